// File: doc/BRIEF.md
# Leaf Page Entry Access Guard with Reference/Change Update

This block judges one memory access against a leaf page table entry that a translation walker has already fetched. It is given the 64-bit entry, the address the entry was read from, the kind of access (load, store or instruction fetch), the problem-state flag and the key-0 deny bits of the data and instruction access-mask registers. It reports the permission set it grants, whether the access faults, and a small vector of cause bits.

When the access is allowed, the block marks the entry as referenced and, for a store, as changed. It writes the updated entry back to memory through a 64-bit write port with a request/acknowledge handshake. The write is issued only when the update actually alters the entry. A store is the only access that is granted write permission. A load or fetch therefore leaves the change bit clear, and a later store has to come back through this block to set it.

The control is a four-state machine. `ST_IDLE` waits for `start` and captures the inputs, then moves to `ST_EVAL`. `ST_EVAL` registers the verdict and the merged entry. From there it moves to `ST_WRITE` when a write-back is needed, or to `ST_FIN` otherwise. `ST_WRITE` holds the request until it is acknowledged and then moves to `ST_FIN`. `ST_FIN` raises `done` for one cycle and returns to `ST_IDLE`.

Top module: `pte_guard_rc`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `wr_req` and `fault` are 0 and `grant` is 0.
- R2: Entry bits [3:0] are the authority field: bit 3 marks a privileged page, bit 2 allows read, bit 1 allows read and write, and bit 0 allows execute. `grant` is encoded as {execute, write, read} in bits [2:0].
- R3: A privileged page accessed with `prob_state`=1 is granted nothing, and any access to it faults.
- R4: A supervisor access (`prob_state`=0) to a non-privileged page has its permissions masked. `amr_key[1]`=1 removes write, `amr_key[0]`=1 removes read, and `iamr_key`=1 removes execute.
- R5: The mask bits have no effect on problem-state accesses or on privileged pages accessed in supervisor state.
- R6: An instruction fetch from a page whose attribute bits [5:4] equal 2'b10 faults with `cause` bit 1 (guarded no-execute) set and `cause` bit 0 clear. Loads and stores to such a page are not affected by this rule.
- R7: If the requested kind (`acc_kind` 0 = load needs read, 1 = store needs write, 2 = fetch needs execute) is not granted, the access faults with `cause` bit 0 set. A faulting store also sets `cause` bit 2. A faulting access reports `grant` = 0.
- R8: On an allowed access, the written entry has bit 8 (reference) set. Bit 7 (change) is also set when the access is a store. All other bits match the input entry.
- R9: An allowed load or fetch reports `grant` with the write bit cleared. An allowed store reports the full granted set.
- R10: A write is requested only when the access is allowed and the updated entry differs from the input entry. The write goes to `wr_addr` equal to the captured `pte_addr`.
- R11: `wr_req` stays high with stable `wr_addr` and `wr_data` until a cycle in which `wr_ack` is high. `done` rises in the cycle after that acknowledge and lasts exactly one cycle.
- R12: When no write is needed, `done` is high in the second cycle after the clock edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check; inputs sampled in the idle state |
| pte_in | input | 64 | Leaf page table entry |
| pte_addr | input | ADDR_W | Memory address of the entry |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch |
| prob_state | input | 1 | 1 = problem (user) state |
| amr_key | input | 2 | Key-0 data deny bits: [1] write, [0] read |
| iamr_key | input | 1 | Key-0 instruction deny bit |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Access denied (valid from done) |
| cause | output | 3 | [0] protection, [1] guarded no-execute, [2] store |
| grant | output | 3 | Granted {execute, write, read} |
| wr_req | output | 1 | Write-back request |
| wr_addr | output | ADDR_W | Write-back address |
| wr_data | output | 64 | Updated entry |
| wr_ack | input | 1 | Write-back acknowledge |

## Verification
The hardest condition to reach from the ports is a write request that is kept waiting. The bench drives a load to an unreferenced page and then withholds `wr_ack` for several cycles. During that wait it confirms that the request stays high, the data stays put and `done` stays low. The other hard case is an allowed access that needs no write-back. It is reached by presenting an entry whose reference bit, and for a store also its change bit, are already set. The bench then checks that `done` arrives without any request.

// File: rtl/pte_guard_pkg.sv
package pte_guard_pkg;
    localparam int PTE_W   = 64;
    localparam int CAUSE_W = 3;
    localparam int REF_BIT = 8;
    localparam int CHG_BIT = 7;
    localparam int ATT_LO  = 4;
    localparam logic [1:0] ATT_NIO = 2'b10;

    localparam int CZ_PROT  = 0;
    localparam int CZ_GUARD = 1;
    localparam int CZ_STORE = 2;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVAL  = 2'd1,
        ST_WRITE = 2'd2,
        ST_FIN   = 2'd3
    } st_e;
endpackage

// File: rtl/pte_perm_eval.sv
module pte_perm_eval
    import pte_guard_pkg::*;
(
    input  logic [PTE_W-1:0]   pte,
    input  logic [1:0]         kind,
    input  logic               prob,
    input  logic [1:0]         amr_key,
    input  logic               iamr_key,
    output perm_t              grant,
    output logic               fault,
    output logic [CAUSE_W-1:0] cause
);
    perm_t base, prot, need;
    logic  priv, guarded, is_store;

    always_comb begin
        priv     = pte[3];
        base.r   = pte[2] | pte[1];
        base.w   = pte[1];
        base.x   = pte[0];
        is_store = (kind == ACC_STORE);
        guarded  = (pte[ATT_LO+1:ATT_LO] == ATT_NIO) && (kind == ACC_FETCH);

        if (priv && prob) begin
            prot = '0;
        end else if (prob || priv) begin
            prot = base;
        end else begin
            prot.r = base.r & ~amr_key[0];
            prot.w = base.w & ~amr_key[1];
            prot.x = base.x & ~iamr_key;
        end

        need = '0;
        unique case (kind)
            ACC_STORE: need.w = 1'b1;
            ACC_FETCH: need.x = 1'b1;
            default:   need.r = 1'b1;
        endcase

        cause = '0;
        fault = 1'b0;
        grant = prot;
        if (guarded) begin
            fault           = 1'b1;
            cause[CZ_GUARD] = 1'b1;
        end else if ((need & ~prot) != '0) begin
            fault           = 1'b1;
            cause[CZ_PROT]  = 1'b1;
            cause[CZ_STORE] = is_store;
        end
        if (fault) begin
            grant = '0;
        end else if (!is_store) begin
            grant.w = 1'b0;
        end
    end
endmodule

// File: rtl/pte_rc_merge.sv
module pte_rc_merge
    import pte_guard_pkg::*;
(
    input  logic [PTE_W-1:0] pte,
    input  logic             is_store,
    output logic [PTE_W-1:0] new_pte,
    output logic             changed
);
    always_comb begin
        new_pte          = pte;
        new_pte[REF_BIT] = 1'b1;
        if (is_store) begin
            new_pte[CHG_BIT] = 1'b1;
        end
        changed = (new_pte != pte);
    end
endmodule

// File: rtl/pte_guard_rc.sv
module pte_guard_rc
    import pte_guard_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [PTE_W-1:0]   pte_in,
    input  logic [ADDR_W-1:0]  pte_addr,
    input  logic [1:0]         acc_kind,
    input  logic               prob_state,
    input  logic [1:0]         amr_key,
    input  logic               iamr_key,
    output logic               done,
    output logic               fault,
    output logic [CAUSE_W-1:0] cause,
    output logic [2:0]         grant,
    output logic               wr_req,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [PTE_W-1:0]   wr_data,
    input  logic               wr_ack
);
    st_e                state, state_nx;
    logic [PTE_W-1:0]   pte_q, npte_q, npte_c;
    logic [ADDR_W-1:0]  addr_q;
    logic [1:0]         kind_q, amr_q;
    logic               prob_q, iamr_q, fault_q, fault_c, changed_c;
    logic [CAUSE_W-1:0] cause_q, cause_c;
    perm_t              grant_q, grant_c;

    pte_perm_eval u_eval (
        .pte      (pte_q),
        .kind     (kind_q),
        .prob     (prob_q),
        .amr_key  (amr_q),
        .iamr_key (iamr_q),
        .grant    (grant_c),
        .fault    (fault_c),
        .cause    (cause_c)
    );

    pte_rc_merge u_merge (
        .pte      (pte_q),
        .is_store (kind_q == ACC_STORE),
        .new_pte  (npte_c),
        .changed  (changed_c)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_EVAL;
            ST_EVAL:  state_nx = (!fault_c && changed_c) ? ST_WRITE : ST_FIN;
            ST_WRITE: if (wr_ack) state_nx = ST_FIN;
            ST_FIN:   state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pte_q   <= '0;
            npte_q  <= '0;
            addr_q  <= '0;
            kind_q  <= '0;
            amr_q   <= '0;
            prob_q  <= 1'b0;
            iamr_q  <= 1'b0;
            fault_q <= 1'b0;
            cause_q <= '0;
            grant_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start) begin
                pte_q   <= pte_in;
                addr_q  <= pte_addr;
                kind_q  <= acc_kind;
                prob_q  <= prob_state;
                amr_q   <= amr_key;
                iamr_q  <= iamr_key;
                fault_q <= 1'b0;
                cause_q <= '0;
                grant_q <= '0;
            end
            if (state == ST_EVAL) begin
                fault_q <= fault_c;
                cause_q <= cause_c;
                grant_q <= grant_c;
                npte_q  <= npte_c;
            end
        end
    end

    always_comb begin
        done    = (state == ST_FIN);
        wr_req  = (state == ST_WRITE);
        wr_addr = addr_q;
        wr_data = npte_q;
        fault   = fault_q;
        cause   = cause_q;
        grant   = grant_q;
    end
endmodule

// File: rtl/pte_guard_rc_chk.sv
module pte_guard_rc_chk
    import pte_guard_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              fault,
    input logic [2:0]        grant,
    input logic              wr_req,
    input logic              wr_ack,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [PTE_W-1:0]  wr_data,
    input logic [PTE_W-1:0]  pte_q
);
    assert_wr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_data) && $stable(wr_addr)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_ack_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ack) |=> done);

    assert_no_write_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (!fault && wr_data != pte_q));

    assert_ref_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> wr_data[REF_BIT]);

    assert_fault_nogrant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (grant == 3'b000));

    assert_req_done_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req && done));
endmodule

bind pte_guard_rc pte_guard_rc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (done),
    .fault   (fault),
    .grant   (grant),
    .wr_req  (wr_req),
    .wr_ack  (wr_ack),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pte_q   (pte_q)
);

// File: tb/pte_guard_rc_test.sv
module pte_guard_rc_test;
    localparam int AW = 48;
    localparam logic [63:0] B = 64'h0000_00AB_CDE0_0000;

    typedef struct packed {
        logic [63:0] pte;
        logic [1:0]  kind;
        logic        prob;
        logic [1:0]  amr;
        logic        iamr;
        logic        xf;
        logic [2:0]  xc;
        logic [2:0]  xg;
        logic        xw;
        logic [63:0] xd;
    } vec_t;

    localparam int VN = 15;
    localparam vec_t VECS [VN] = '{
        '{B|64'h004, 2'd0, 1'b0, 2'b00, 1'b0, 1'b0, 3'b000, 3'b001, 1'b1, B|64'h104},
        '{B|64'h002, 2'd1, 1'b0, 2'b00, 1'b0, 1'b0, 3'b000, 3'b011, 1'b1, B|64'h182},
        '{B|64'h002, 2'd1, 1'b0, 2'b10, 1'b0, 1'b1, 3'b101, 3'b000, 1'b0, 64'h0},
        '{B|64'h002, 2'd0, 1'b0, 2'b01, 1'b0, 1'b1, 3'b001, 3'b000, 1'b0, 64'h0},
        '{B|64'h001, 2'd2, 1'b0, 2'b00, 1'b1, 1'b1, 3'b001, 3'b000, 1'b0, 64'h0},
        '{B|64'h101, 2'd2, 1'b1, 2'b00, 1'b1, 1'b0, 3'b000, 3'b100, 1'b0, 64'h0},
        '{B|64'h00C, 2'd0, 1'b1, 2'b00, 1'b0, 1'b1, 3'b001, 3'b000, 1'b0, 64'h0},
        '{B|64'h00C, 2'd0, 1'b0, 2'b01, 1'b0, 1'b0, 3'b000, 3'b001, 1'b1, B|64'h10C},
        '{B|64'h021, 2'd2, 1'b0, 2'b00, 1'b0, 1'b1, 3'b010, 3'b000, 1'b0, 64'h0},
        '{B|64'h024, 2'd0, 1'b0, 2'b00, 1'b0, 1'b0, 3'b000, 3'b001, 1'b1, B|64'h124},
        '{B|64'h183, 2'd1, 1'b0, 2'b00, 1'b0, 1'b0, 3'b000, 3'b111, 1'b0, 64'h0},
        '{B|64'h004, 2'd2, 1'b1, 2'b00, 1'b0, 1'b1, 3'b001, 3'b000, 1'b0, 64'h0},
        '{B|64'h002, 2'd1, 1'b1, 2'b11, 1'b0, 1'b0, 3'b000, 3'b011, 1'b1, B|64'h182},
        '{B|64'h004, 2'd1, 1'b1, 2'b00, 1'b0, 1'b1, 3'b101, 3'b000, 1'b0, 64'h0},
        '{B|64'h003, 2'd0, 1'b0, 2'b00, 1'b1, 1'b0, 3'b000, 3'b001, 1'b1, B|64'h103}
    };

    logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0, wr_ack = 1'b0;
    logic [63:0]   pte_in = '0;
    logic [AW-1:0] pte_addr = '0;
    logic [1:0]    acc_kind = '0, amr_key = '0;
    logic          prob_state = 1'b0, iamr_key = 1'b0;
    logic          done, fault, wr_req;
    logic [2:0]    cause, grant;
    logic [AW-1:0] wr_addr;
    logic [63:0]   wr_data;

    int n_run = 0, n_fail = 0;
    int ncyc, nwr;
    logic [63:0]   got_d;
    logic [AW-1:0] got_a;

    always #10 clk = ~clk;

    pte_guard_rc #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .pte_in(pte_in),
        .pte_addr(pte_addr), .acc_kind(acc_kind), .prob_state(prob_state),
        .amr_key(amr_key), .iamr_key(iamr_key), .done(done), .fault(fault),
        .cause(cause), .grant(grant), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ack(wr_ack)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // Issue one check; ack_delay = negedges to wait before acknowledging
    task automatic issue(input vec_t v, input logic [AW-1:0] a, input int ack_delay);
        @(negedge clk);
        pte_in = v.pte; acc_kind = v.kind; prob_state = v.prob;
        amr_key = v.amr; iamr_key = v.iamr; pte_addr = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ncyc = 0; nwr = 0; got_d = '0; got_a = '0;
        while (!done && ncyc < 30) begin
            if (wr_req) begin
                for (int k = 0; k < ack_delay; k++) begin
                    check("R11 req held", {63'd0, wr_req}, 64'd1);
                    check("R11 no early done", {63'd0, done}, 64'd0);
                    check("R11 data stable", wr_data, got_d === '0 ? wr_data : got_d);
                    got_d = wr_data;
                    @(negedge clk); ncyc++;
                end
                nwr++; got_d = wr_data; got_a = wr_addr; wr_ack = 1'b1;
            end
            @(negedge clk);
            wr_ack = 1'b0; ncyc++;
        end
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 done in reset", {63'd0, done}, 64'd0);
        check("R1 wr_req in reset", {63'd0, wr_req}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 fault after reset", {63'd0, fault}, 64'd0);
        check("R1 grant after reset", {61'd0, grant}, 64'd0);
        check("R1 done after reset", {63'd0, done}, 64'd0);

        for (int i = 0; i < VN; i++) begin
            issue(VECS[i], AW'(48'h1000 + i * 8), 0);
            check($sformatf("R7 fault v%0d", i), {63'd0, fault}, {63'd0, VECS[i].xf});
            check($sformatf("R6 R7 cause v%0d", i), {61'd0, cause}, {61'd0, VECS[i].xc});
            check($sformatf("R2 R3 R4 R5 R9 grant v%0d", i), {61'd0, grant}, {61'd0, VECS[i].xg});
            check($sformatf("R10 writes v%0d", i), 64'(nwr), VECS[i].xw ? 64'd1 : 64'd0);
            check($sformatf("R12 latency v%0d", i), 64'(ncyc), VECS[i].xw ? 64'd2 : 64'd1);
            if (VECS[i].xw) begin
                check($sformatf("R8 data v%0d", i), got_d, VECS[i].xd);
                check($sformatf("R10 addr v%0d", i), 64'(got_a), 64'(48'h1000 + i * 8));
            end
            @(negedge clk);
            check($sformatf("R11 done one cycle v%0d", i), {63'd0, done}, 64'd0);
        end

        // Stalled acknowledge: load to an unreferenced page, ack held back
        issue(VECS[0], AW'(48'hABC0), 4);
        check("R11 delayed write count", 64'(nwr), 64'd1);
        check("R11 delayed data", got_d, B | 64'h104);
        check("R11 delayed latency", 64'(ncyc), 64'd6);
        @(negedge clk);
        check("R11 done dropped", {63'd0, done}, 64'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule